// File: doc/BRIEF.md
# Converter Calibration Mode Sequencer

This block sits in the digital back end of a sigma-delta converter and runs its calibration and conversion sequences. Software writes a two-bit mode field in a setup register. A non-zero mode starts a sequence that is timed in output-rate periods. During the sequence the block captures the filtered conversion results that arrive from outside into a zero-scale and a full-scale coefficient register. The mode field clears itself when the calibration part of the sequence finishes. A data-ready flag, active low, tells software when a fresh result is waiting.

Two kinds of calibration are offered. A self-calibration is a single command that measures both points. A system calibration is a pair of separate commands, zero-scale first and full-scale second, each measuring the input the system presents. Every sequence ends with one ordinary conversion. When the sequencer is idle, each arriving result goes straight to the data register.

The modulator, the decimation filter and the arithmetic that applies the coefficients live outside this block.

Top module: `cal_seq_top`

## Requirements
- R1: After reset the mode field reads 00 and data-ready is high. The data register holds 0, the zero-scale coefficient holds 0x800000 and the full-scale coefficient holds 0x5A0000.
- R2: The register port uses the address to pick the register. Address 0 is setup, with the mode in bits [1:0] and zeros above. Address 1 is the data register, address 2 the zero-scale coefficient and address 3 the full-scale coefficient. Read data is combinational. A write to any address other than 0 has no effect.
- R3: While idle, a result strobe loads the data register and drives data-ready low on the next clock. A read strobe at address 1 returns data-ready to high.
- R4: Mode 01 (self-calibration) loads the zero-scale coefficient on the 3rd output-rate tick after the command and the full-scale coefficient on the 6th. The mode field reads 00 from the 6th tick on. Each coefficient takes the most recent result strobed within its 3-period window.
- R5: After a mode 01 command, data-ready stays high until the 9th tick. At that tick it falls and the data register takes the latest result of periods 7 to 9.
- R6: Mode 10 (system zero-scale) loads only the zero-scale coefficient, on the 3rd tick, and the mode field reads 00 from then on. Data-ready falls on the 4th tick, with the data register loaded from the 4th period.
- R7: Mode 11 (system full-scale) loads only the full-scale coefficient, on the 3rd tick, and the mode field clears at that tick. Data-ready falls on the 4th tick.
- R8: A calibration command sets data-ready high on the first modulator tick after the write, so the rise lags by at most one modulator cycle. Data-ready then stays high until the sequence's final tick.
- R9: When the bipolar input is high at the moment the zero-scale coefficient loads, the value is stored with bit 23 inverted, which re-references the midscale code to zero. The full-scale coefficient is never altered by this input.
- R10: A setup write during a sequence abandons it. The sequence restarts with the new mode, or the block goes idle for mode 00. Coefficients keep their last completed values until a step finishes.
- R11: Results strobed during a sequence do not reach the data register or data-ready before the final tick. A window that receives no result leaves its target register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acts on data-ready for address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2 | Setup write value (mode field) |
| reg_rdata | output | 24 | Read data for reg_addr |
| rate_tick | input | 1 | One-cycle pulse per output-rate period |
| mod_tick | input | 1 | One-cycle pulse per modulator cycle |
| res_vld | input | 1 | Conversion result strobe |
| res_data | input | 24 | Conversion result |
| bipolar | input | 1 | High for bipolar input range |
| drdy | output | 1 | Data-ready flag, low when a new result is waiting |

## Verification
A table of sequences drives every calibration mode under both polarities, and each one is checked at its timing points. Those checks separate the 3-tick from the 6-tick coefficient loads and the 4-tick from the 9-tick data-ready fall. Every window strobes a junk value before the real one, which shows that the most recent result is the one captured. Bipolar runs of mode 11 confirm that only the zero-scale path is re-referenced. Directed cases cover the modulator-tick lag of data-ready, aborts partway through a step and aborts to idle, windows with no result, and writes to read-only addresses.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    typedef enum logic [1:0] {
        MODE_NORM   = 2'b00,
        MODE_SELF   = 2'b01,
        MODE_SYS_ZS = 2'b10,
        MODE_SYS_FS = 2'b11
    } cal_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ZERO,
        PH_FULL,
        PH_CONV
    } cal_phase_e;
endpackage

// File: rtl/cal_period_cnt.sv
module cal_period_cnt #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank #(
    parameter int            DW     = 24,
    parameter logic [DW-1:0] ZS_RST = '0,
    parameter logic [DW-1:0] FS_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_zs,
    input  logic          ld_fs,
    input  logic          bipolar,
    input  logic [DW-1:0] val,
    output logic [DW-1:0] zs,
    output logic [DW-1:0] fs
);
    typedef struct packed {
        logic [DW-1:0] zs;
        logic [DW-1:0] fs;
    } coef_t;

    coef_t d, q;

    always_comb begin
        d = q;
        if (ld_zs) d.zs = bipolar ? {~val[DW-1], val[DW-2:0]} : val;
        if (ld_fs) d.fs = val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{zs: ZS_RST, fs: FS_RST};
        else        q <= d;
    end

    assign zs = q.zs;
    assign fs = q.fs;

    // R4: the two windows never end together
    p_single_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_zs && ld_fs));

    // R9: bipolar loads flip the top bit of the captured value
    p_bipolar_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_zs && bipolar) |=> (q.zs[DW-1] != $past(val[DW-1])));
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
    import cal_seq_pkg::*;
#(
    parameter int DW          = 24,
    parameter int CW          = 2,
    parameter int ZS_N        = 3,
    parameter int FS_N        = 3,
    parameter int SELF_CONV_N = 3,
    parameter int SYS_CONV_N  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [1:0]    cmd_mode,
    input  logic          data_rd,
    input  logic          rate_tick,
    input  logic          mod_tick,
    input  logic          res_vld,
    input  logic [DW-1:0] res_data,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_tick,
    output logic          ld_zs,
    output logic          ld_fs,
    output logic [DW-1:0] cap_val,
    output logic [1:0]    mode,
    output logic [DW-1:0] data,
    output logic          drdy
);
    typedef struct packed {
        cal_phase_e    phase;
        cal_mode_e     mode;
        cal_mode_e     seq;
        logic [DW-1:0] shadow;
        logic          got;
        logic [DW-1:0] data;
        logic          drdy;
        logic          pend;
    } st_t;

    st_t  d, q;
    int   last_idx;
    logic active, phase_end, cap_ok;

    always_comb begin
        case (q.phase)
            PH_ZERO: last_idx = ZS_N - 1;
            PH_FULL: last_idx = FS_N - 1;
            PH_CONV: last_idx = (q.seq == MODE_SELF) ? SELF_CONV_N - 1 : SYS_CONV_N - 1;
            default: last_idx = 0;
        endcase
    end

    assign active    = (q.phase != PH_IDLE);
    assign phase_end = active && rate_tick && (cnt == CW'(last_idx));
    assign cap_ok    = res_vld || q.got;
    assign cap_val   = res_vld ? res_data : q.shadow;
    assign cnt_tick  = active && rate_tick;

    always_comb begin
        d       = q;
        ld_zs   = 1'b0;
        ld_fs   = 1'b0;
        cnt_clr = 1'b0;

        if (!active && res_vld) begin
            d.data = res_data;
            d.drdy = 1'b0;
        end else if (!active && data_rd) begin
            d.drdy = 1'b1;
        end

        if (active && res_vld) begin
            d.shadow = res_data;
            d.got    = 1'b1;
        end

        if (q.pend && mod_tick) begin
            d.drdy = 1'b1;
            d.pend = 1'b0;
        end

        if (phase_end) begin
            cnt_clr = 1'b1;
            d.got   = 1'b0;
            case (q.phase)
                PH_ZERO: begin
                    ld_zs = cap_ok;
                    if (q.seq == MODE_SELF) begin
                        d.phase = PH_FULL;
                    end else begin
                        d.phase = PH_CONV;
                        d.mode  = MODE_NORM;
                    end
                end
                PH_FULL: begin
                    ld_fs   = cap_ok;
                    d.phase = PH_CONV;
                    d.mode  = MODE_NORM;
                end
                PH_CONV: begin
                    if (cap_ok) d.data = cap_val;
                    d.drdy  = 1'b0;
                    d.pend  = 1'b0;
                    d.phase = PH_IDLE;
                end
                default: ;
            endcase
        end

        if (cmd_wr) begin
            ld_zs   = 1'b0;
            ld_fs   = 1'b0;
            cnt_clr = 1'b1;
            d.data  = q.data;
            d.drdy  = q.drdy;
            d.got   = 1'b0;
            d.mode  = cal_mode_e'(cmd_mode);
            d.seq   = cal_mode_e'(cmd_mode);
            case (cal_mode_e'(cmd_mode))
                MODE_NORM: begin
                    d.phase = PH_IDLE;
                    d.pend  = 1'b0;
                end
                MODE_SYS_FS: begin
                    d.phase = PH_FULL;
                    d.pend  = 1'b1;
                end
                default: begin
                    d.phase = PH_ZERO;
                    d.pend  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, mode: MODE_NORM, seq: MODE_NORM, shadow: '0,
                   got: 1'b0, data: '0, drdy: 1'b1, pend: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mode = q.mode;
    assign data = q.data;
    assign drdy = q.drdy;

    // R8: once the modulator tick has passed, data-ready is high for the whole sequence
    p_drdy_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !q.pend) |-> q.drdy);

    // R4: the period counter stays inside the current window
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= CW'(last_idx)));

    // R6: the mode field is already clear during the trailing conversion
    p_mode_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_CONV) |-> (q.mode == MODE_NORM));

    // R5: data-ready falls only at the end of a sequence or on an idle result
    p_drdy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.drdy) |-> ($past(q.phase) == PH_CONV || $past(q.phase) == PH_IDLE));

    // R11: results inside a sequence leave the data register alone
    p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && res_vld && !cmd_wr && !phase_end) |=> $stable(q.data));
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
    import cal_seq_pkg::*;
#(
    parameter int            DW          = 24,
    parameter int            ZS_N        = 3,
    parameter int            FS_N        = 3,
    parameter int            SELF_CONV_N = 3,
    parameter int            SYS_CONV_N  = 1,
    parameter logic [DW-1:0] ZS_RST      = 24'h800000,
    parameter logic [DW-1:0] FS_RST      = 24'h5A0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [1:0]    reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          rate_tick,
    input  logic          mod_tick,
    input  logic          res_vld,
    input  logic [DW-1:0] res_data,
    input  logic          bipolar,
    output logic          drdy
);
    localparam int MAX_A = (ZS_N > FS_N) ? ZS_N : FS_N;
    localparam int MAX_B = (SELF_CONV_N > SYS_CONV_N) ? SELF_CONV_N : SYS_CONV_N;
    localparam int MAX_N = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = ($clog2(MAX_N) < 1) ? 1 : $clog2(MAX_N);

    localparam logic [1:0] A_SETUP = 2'd0;
    localparam logic [1:0] A_DATA  = 2'd1;
    localparam logic [1:0] A_ZS    = 2'd2;
    localparam logic [1:0] A_FS    = 2'd3;

    logic          cmd_wr, data_rd;
    logic          cnt_clr, cnt_tick, ld_zs, ld_fs;
    logic [CW-1:0] cnt;
    logic [DW-1:0] cap_val, data, zs, fs;
    logic [1:0]    mode;

    assign cmd_wr  = reg_wr && (reg_addr == A_SETUP);
    assign data_rd = reg_rd && (reg_addr == A_DATA);

    cal_period_cnt #(.CW(CW)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (cnt_tick),
        .cnt   (cnt)
    );

    cal_seq_ctrl #(
        .DW          (DW),
        .CW          (CW),
        .ZS_N        (ZS_N),
        .FS_N        (FS_N),
        .SELF_CONV_N (SELF_CONV_N),
        .SYS_CONV_N  (SYS_CONV_N)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_mode  (reg_wdata),
        .data_rd   (data_rd),
        .rate_tick (rate_tick),
        .mod_tick  (mod_tick),
        .res_vld   (res_vld),
        .res_data  (res_data),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .cnt_tick  (cnt_tick),
        .ld_zs     (ld_zs),
        .ld_fs     (ld_fs),
        .cap_val   (cap_val),
        .mode      (mode),
        .data      (data),
        .drdy      (drdy)
    );

    cal_coef_bank #(
        .DW     (DW),
        .ZS_RST (ZS_RST),
        .FS_RST (FS_RST)
    ) coef_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_zs   (ld_zs),
        .ld_fs   (ld_fs),
        .bipolar (bipolar),
        .val     (cap_val),
        .zs      (zs),
        .fs      (fs)
    );

    always_comb begin
        case (reg_addr)
            A_SETUP: reg_rdata = {{(DW-2){1'b0}}, mode};
            A_DATA:  reg_rdata = data;
            A_ZS:    reg_rdata = zs;
            default: reg_rdata = fs;
        endcase
    end
endmodule

// File: tb/cal_seq_top_tb_top.sv
module cal_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0, reg_wdata = 2'd0;
    logic [23:0] reg_rdata;
    logic        rate_tick = 1'b0, mod_tick = 1'b0, res_vld = 1'b0, bipolar = 1'b0;
    logic [23:0] res_data = '0;
    logic        drdy;

    int checks = 0;
    int errs   = 0;
    logic [23:0] mdl_zs, mdl_fs, mdl_data;

    always #10 clk = ~clk;

    cal_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rate_tick(rate_tick), .mod_tick(mod_tick), .res_vld(res_vld),
        .res_data(res_data), .bipolar(bipolar), .drdy(drdy)
    );

    // {mode, bipolar, zero value, full value, conversion value}
    localparam logic [74:0] VEC [0:5] = '{
        {2'b01, 1'b0, 24'h000123, 24'h7FF000, 24'h345678},
        {2'b01, 1'b1, 24'h800010, 24'h6ABCDE, 24'h123456},
        {2'b10, 1'b0, 24'h000777, 24'h000000, 24'h0ABCDE},
        {2'b11, 1'b0, 24'h000000, 24'h7A0000, 24'h00F00D},
        {2'b10, 1'b1, 24'h7FFFF0, 24'h000000, 24'h111111},
        {2'b11, 1'b1, 24'h000000, 24'h654321, 24'h222222}
    };

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [1:0] a, input logic [23:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] v);
        @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_data;
        @(negedge clk); reg_addr = 2'd1; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic rate;
        @(negedge clk); rate_tick = 1'b1;
        @(negedge clk); rate_tick = 1'b0;
    endtask

    task automatic modt;
        @(negedge clk); mod_tick = 1'b1;
        @(negedge clk); mod_tick = 1'b0;
    endtask

    task automatic res(input logic [23:0] v);
        @(negedge clk); res_vld = 1'b1; res_data = v;
        @(negedge clk); res_vld = 1'b0;
    endtask

    task automatic run_seq(input logic [1:0] m, input logic bip,
                           input logic [23:0] zv, input logic [23:0] fv, input logic [23:0] cv);
        int total, calend;
        logic [23:0] v;
        total  = (m == 2'b01) ? 9 : 4;
        calend = (m == 2'b01) ? 6 : 3;
        bipolar = bip;
        wr(2'd0, m);
        chk_reg("R2 mode readback", 2'd0, {22'd0, m});
        modt();
        chk("R8 drdy high after mod tick", {23'd0, drdy}, 24'd1);
        for (int p = 1; p <= total; p++) begin
            if (m == 2'b01) v = (p <= 3) ? zv : (p <= 6) ? fv : cv;
            else if (m == 2'b10) v = (p <= 3) ? zv : cv;
            else v = (p <= 3) ? fv : cv;
            res(24'hA5A500 ^ 24'(p));
            res(v);
            if (p == total) begin
                chk("R11 drdy held before final tick", {23'd0, drdy}, 24'd1);
                chk_reg("R11 data untouched in sequence", 2'd1, mdl_data);
            end
            rate();
            if (m == 2'b01 && p == 3) begin
                mdl_zs = zv ^ (bip ? 24'h800000 : 24'h0);
                chk_reg("R4 zero coef at tick 3", 2'd2, mdl_zs);
                chk_reg("R4 mode still set mid-sequence", 2'd0, 24'd1);
            end
            if (p == calend) begin
                if (m == 2'b10) mdl_zs = zv ^ (bip ? 24'h800000 : 24'h0);
                if (m != 2'b10) mdl_fs = fv;
                chk_reg("R6 R7 mode cleared at calibration end", 2'd0, 24'd0);
                chk_reg("R6 zero coef", 2'd2, mdl_zs);
                chk_reg("R7 R9 full coef", 2'd3, mdl_fs);
            end
        end
        mdl_data = cv;
        chk("R5 drdy low after final tick", {23'd0, drdy}, 24'd0);
        chk_reg("R5 data after final tick", 2'd1, mdl_data);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        mdl_zs = 24'h800000; mdl_fs = 24'h5A0000; mdl_data = 24'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_reg("R1 mode reset", 2'd0, 24'd0);
        chk_reg("R1 data reset", 2'd1, 24'd0);
        chk_reg("R1 zero coef reset", 2'd2, 24'h800000);
        chk_reg("R1 full coef reset", 2'd3, 24'h5A0000);
        chk("R1 drdy reset", {23'd0, drdy}, 24'd1);

        // R2 write to non-setup address ignored
        wr(2'd1, 2'b01);
        rate(); rate(); rate();
        chk_reg("R2 stray write leaves mode", 2'd0, 24'd0);
        chk_reg("R2 stray write leaves zero coef", 2'd2, mdl_zs);

        // R3 idle conversions
        res(24'h000111);
        mdl_data = 24'h000111;
        chk_reg("R3 idle result loads data", 2'd1, mdl_data);
        chk("R3 drdy low on result", {23'd0, drdy}, 24'd0);
        rd_data();
        chk("R3 drdy high after read", {23'd0, drdy}, 24'd1);
        res(24'h000222);
        mdl_data = 24'h000222;
        chk_reg("R3 second result", 2'd1, mdl_data);

        // vector table: all modes, both polarities (R4..R9, R11)
        for (int i = 0; i < 6; i++) begin
            run_seq(VEC[i][74:73], VEC[i][72], VEC[i][71:48], VEC[i][47:24], VEC[i][23:0]);
        end
        bipolar = 1'b0;

        // R10 abort in full-scale window, restart as system zero-scale
        wr(2'd0, 2'b01);
        modt();
        for (int p = 1; p <= 3; p++) begin res(24'h0000AA); rate(); end
        mdl_zs = 24'h0000AA;
        chk_reg("R10 zero coef before abort", 2'd2, mdl_zs);
        res(24'h0000BB); rate();
        res(24'h0000BB); rate();
        wr(2'd0, 2'b10);
        chk_reg("R10 restart mode", 2'd0, 24'd2);
        chk_reg("R10 full coef kept on abort", 2'd3, mdl_fs);
        modt();
        for (int p = 1; p <= 4; p++) begin
            res((p <= 3) ? 24'h0000CC : 24'h0000DD);
            rate();
            if (p == 3) begin
                mdl_zs = 24'h0000CC;
                chk_reg("R10 restarted zero coef", 2'd2, mdl_zs);
            end
        end
        mdl_data = 24'h0000DD;
        chk_reg("R10 data after restarted step", 2'd1, mdl_data);
        chk_reg("R10 full coef untouched", 2'd3, mdl_fs);

        // R10 abort to idle
        rd_data();
        wr(2'd0, 2'b01);
        modt();
        res(24'h0000EE); rate();
        wr(2'd0, 2'b00);
        chk_reg("R10 abort to idle mode", 2'd0, 24'd0);
        rate(); rate(); rate();
        chk_reg("R10 zero coef kept after idle abort", 2'd2, mdl_zs);
        chk("R10 drdy stays high after idle abort", {23'd0, drdy}, 24'd1);

        // R11 step with no results
        wr(2'd0, 2'b11);
        modt();
        for (int p = 1; p <= 4; p++) rate();
        chk_reg("R11 full coef kept without result", 2'd3, mdl_fs);
        chk_reg("R11 data kept without result", 2'd1, mdl_data);
        chk("R7 drdy low at tick 4", {23'd0, drdy}, 24'd0);

        // R8 rise lags until modulator tick
        wr(2'd0, 2'b10);
        chk("R8 drdy still low before mod tick", {23'd0, drdy}, 24'd0);
        modt();
        chk("R8 drdy high after mod tick", {23'd0, drdy}, 24'd1);
        wr(2'd0, 2'b00);
        chk_reg("R10 idle after final abort", 2'd0, 24'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule